// File: doc/BRIEF.md
# Outbound Post Queue Read Port with Prefetch

The block answers host reads of an outbound message queue. The local processor writes message frame addresses into a circular list held in shared memory and then pulses a head-advance strobe. A host read either pops the oldest address from the list or, when head and tail are equal, returns an all-ones sentinel and leaves every pointer where it was.

Memory latency is hidden by a one-entry prefetch register. Whenever the list holds entries and the register is free, the block fetches the word at the tail slot. A host read is then answered combinationally in the cycle it is presented. If a read arrives while a fetch is still in flight, the acknowledge is held back until the fetched word has landed, so stale data is never returned. The list lives at byte address `base_i + 2*LIST_BYTES + pointer`. Pointers step by 4 bytes and wrap at `LIST_BYTES`, which must be a power of two. At most `LIST_BYTES/4 - 1` entries may be outstanding, because a full list would be indistinguishable from an empty one.

A level interrupt shows whether the list is non-empty, and a mask register can block it.

Top module: `oq_read_port`

## Requirements
- R1: After reset both pointers are 0, `irq_status_o` and `irq_o` are 0, `irq_mask_o` is 1 and `mem_req_o` is 0.
- R2: A read presented while head equals tail is acknowledged in the same cycle with data 0xFFFFFFFF and leaves the tail pointer unchanged. This holds even if a head strobe occurs in that same cycle.
- R3: A read presented while head differs from tail returns the oldest posted address. It then advances the tail by 4, modulo `LIST_BYTES`.
- R4: Every fetch drives `mem_addr_o = base_i + 2*LIST_BYTES + tail`, using the tail value current in the request cycle.
- R5: Each `head_inc_i` cycle advances the head by 4, modulo `LIST_BYTES`. Without the strobe, the head holds its value.
- R6: A fetch is requested in the cycle after the list becomes non-empty while no word is held, and in the cycle after a pop that leaves the list non-empty. No fetch is requested while the list is empty, and at most one fetch is outstanding. Posting n entries and then draining them costs exactly n fetches.
- R7: A read presented during an outstanding fetch is held unacknowledged. It is answered with the fetched word one cycle after `mem_rvalid_i`. When a read follows a post to an empty list at once, it waits `latency+1` cycles.
- R8: `irq_status_o` is 1 exactly while head differs from tail, and it clears by itself when the pointers meet.
- R9: `irq_o` equals `irq_status_o` when the mask is 0 and is 0 when the mask is 1. A cycle with `mask_we_i` high loads `mask_d_i` into the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | AW | Queue region base byte address |
| rd_req_i | input | 1 | Host read request, held until acknowledged |
| rd_ack_o | output | 1 | Read acknowledge, data valid this cycle |
| rd_data_o | output | DW | Read data or all-ones sentinel |
| head_inc_i | input | 1 | Local processor head-advance strobe |
| head_ptr_o | output | PTR_W | Head pointer, byte offset |
| tail_ptr_o | output | PTR_W | Tail pointer, byte offset |
| mem_req_o | output | 1 | Prefetch read request, one cycle |
| mem_addr_o | output | AW | Prefetch byte address |
| mem_rvalid_i | input | 1 | Prefetch data valid |
| mem_rdata_i | input | DW | Prefetch data |
| mask_we_i | input | 1 | Interrupt mask write enable |
| mask_d_i | input | 1 | Interrupt mask write value |
| irq_mask_o | output | 1 | Interrupt mask register |
| irq_status_o | output | 1 | List non-empty status |
| irq_o | output | 1 | Masked host interrupt |

## Verification
The bench posts bursts of every length from zero to seven on an eight-entry list and then drains each burst plus one extra read. It repeats this for memory latencies of one to three cycles, so the pointers wrap several times. Oldest-first ordering, the fetch count and the sentinel at the end of each burst are checked against a queue model held in the bench. A read issued right after a post to an empty list separates a correctly stalled answer from an early one, with the expected wait of latency plus one. A head strobe that coincides with an empty read shows that the pre-edge state decides the response. A separate sequence toggles the mask while the list is empty and then non-empty, and checks status and interrupt independently.

// File: rtl/oq_pkg.sv
package oq_pkg;
  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_WAIT = 2'd1,
    PF_FULL = 2'd2
  } pf_state_e;

  localparam int unsigned ENTRY_BYTES = 4;
endpackage

// File: rtl/oq_ptrs.sv
module oq_ptrs #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             head_inc_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(oq_pkg::ENTRY_BYTES);

  logic [PTR_W-1:0] head_q, tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (head_inc_i) head_q <= head_q + STEP;
      if (pop_i)      tail_q <= tail_q + STEP;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign empty_o = (head_q == tail_q);
endmodule

// File: rtl/oq_prefetch.sv
module oq_prefetch
  import oq_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned LIST_BYTES = 256,
  parameter int unsigned PTR_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    base_i,
  input  logic [PTR_W-1:0] tail_i,
  input  logic             empty_i,
  input  logic             pop_i,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             pf_valid_o,
  output logic [DW-1:0]    pf_data_o
);
  localparam logic [AW-1:0] LIST_OFS = AW'(2 * LIST_BYTES);

  pf_state_e       state_q, state_d;
  logic [DW-1:0]   data_q;

  // level trigger covers both tail-advance and head-advance-while-empty events
  assign mem_req_o  = (state_q == PF_IDLE) && !empty_i;
  assign mem_addr_o = base_i + LIST_OFS + {{(AW-PTR_W){1'b0}}, tail_i};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PF_IDLE: if (!empty_i)    state_d = PF_WAIT;
      PF_WAIT: if (mem_rvalid_i) state_d = PF_FULL;
      PF_FULL: if (pop_i)        state_d = PF_IDLE;
      default:                   state_d = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PF_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == PF_WAIT && mem_rvalid_i) data_q <= mem_rdata_i;
    end
  end

  assign pf_valid_o = (state_q == PF_FULL);
  assign pf_data_o  = data_q;
endmodule

// File: rtl/oq_irq.sv
module oq_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nonempty_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic mask_o,
  output logic status_o,
  output logic irq_o
);
  logic mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= 1'b1;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign mask_o   = mask_q;
  assign status_o = nonempty_i;
  assign irq_o    = nonempty_i & ~mask_q;
endmodule

// File: rtl/oq_read_port.sv
module oq_read_port
  import oq_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned LIST_BYTES = 256,
  localparam int unsigned PTR_W     = $clog2(LIST_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    base_i,
  input  logic             rd_req_i,
  output logic             rd_ack_o,
  output logic [DW-1:0]    rd_data_o,
  input  logic             head_inc_i,
  output logic [PTR_W-1:0] head_ptr_o,
  output logic [PTR_W-1:0] tail_ptr_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mask_we_i,
  input  logic             mask_d_i,
  output logic             irq_mask_o,
  output logic             irq_status_o,
  output logic             irq_o
);
  logic          empty, pop, pf_valid;
  logic [DW-1:0] pf_data;

  // empty read answers at once with no side effect; non-empty waits for prefetch
  assign pop       = rd_req_i && !empty && pf_valid;
  assign rd_ack_o  = rd_req_i && (empty || pf_valid);
  assign rd_data_o = empty ? '1 : pf_data;

  oq_ptrs #(.PTR_W(PTR_W)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_inc_i (head_inc_i),
    .pop_i      (pop),
    .head_o     (head_ptr_o),
    .tail_o     (tail_ptr_o),
    .empty_o    (empty)
  );

  oq_prefetch #(
    .AW(AW), .DW(DW), .LIST_BYTES(LIST_BYTES), .PTR_W(PTR_W)
  ) u_prefetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_i       (base_i),
    .tail_i       (tail_ptr_o),
    .empty_i      (empty),
    .pop_i        (pop),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .pf_valid_o   (pf_valid),
    .pf_data_o    (pf_data)
  );

  oq_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nonempty_i (!empty),
    .mask_we_i  (mask_we_i),
    .mask_d_i   (mask_d_i),
    .mask_o     (irq_mask_o),
    .status_o   (irq_status_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/oq_read_port_chk.sv
module oq_read_port_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned LIST_BYTES = 256,
  localparam int unsigned PTR_W     = $clog2(LIST_BYTES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    base_i,
  input logic             rd_req_i,
  input logic             rd_ack_o,
  input logic [DW-1:0]    rd_data_o,
  input logic             head_inc_i,
  input logic [PTR_W-1:0] head_ptr_o,
  input logic [PTR_W-1:0] tail_ptr_o,
  input logic             mem_req_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_rvalid_i,
  input logic             irq_mask_o,
  input logic             irq_status_o,
  input logic             irq_o
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(4);

  logic outst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           outst_q <= 1'b0;
    else if (mem_req_o)    outst_q <= 1'b1;
    else if (mem_rvalid_i) outst_q <= 1'b0;
  end

  p_empty_sentinel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && head_ptr_o == tail_ptr_o) |-> (rd_ack_o && rd_data_o == '1));

  p_empty_no_pop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && head_ptr_o == tail_ptr_o) |=> $stable(tail_ptr_o));

  p_pop_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o && head_ptr_o != tail_ptr_o) |=> tail_ptr_o == $past(tail_ptr_o) + STEP);

  p_fetch_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o == base_i + AW'(2 * LIST_BYTES) + AW'(tail_ptr_o));

  p_head_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_inc_i |=> head_ptr_o == $past(head_ptr_o) + STEP);

  p_head_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_inc_i |=> $stable(head_ptr_o));

  p_no_fetch_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (head_ptr_o != tail_ptr_o && !outst_q));

  p_no_stale_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o && head_ptr_o != tail_ptr_o) |-> !outst_q);

  p_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_status_o == (head_ptr_o != tail_ptr_o));

  p_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_o |-> !irq_o);
endmodule

bind oq_read_port oq_read_port_chk #(
  .AW(AW), .DW(DW), .LIST_BYTES(LIST_BYTES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .base_i       (base_i),
  .rd_req_i     (rd_req_i),
  .rd_ack_o     (rd_ack_o),
  .rd_data_o    (rd_data_o),
  .head_inc_i   (head_inc_i),
  .head_ptr_o   (head_ptr_o),
  .tail_ptr_o   (tail_ptr_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .irq_mask_o   (irq_mask_o),
  .irq_status_o (irq_status_o),
  .irq_o        (irq_o)
);

// File: tb/tb_oq_read_port.sv
`timescale 1ns/1ps
module tb_oq_read_port;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned LB = 32;
  localparam int unsigned NE = LB / 4;
  localparam int unsigned PW = $clog2(LB);
  localparam logic [AW-1:0] BASE = 32'h0001_0000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic          rd_req_i = 0, head_inc_i = 0, mask_we_i = 0, mask_d_i = 0;
  logic          rd_ack_o, mem_req_o, mem_rvalid_i, irq_mask_o, irq_status_o, irq_o;
  logic [DW-1:0] rd_data_o, mem_rdata_i;
  logic [AW-1:0] mem_addr_o;
  logic [PW-1:0] head_ptr_o, tail_ptr_o;

  oq_read_port #(.AW(AW), .DW(DW), .LIST_BYTES(LB)) dut (
    .clk_i, .rst_ni, .base_i(BASE), .rd_req_i, .rd_ack_o, .rd_data_o,
    .head_inc_i, .head_ptr_o, .tail_ptr_o, .mem_req_o, .mem_addr_o,
    .mem_rvalid_i, .mem_rdata_i, .mask_we_i, .mask_d_i,
    .irq_mask_o, .irq_status_o, .irq_o
  );

  int n_chk = 0, n_err = 0;
  int lat = 1;
  int fetch_cnt = 0;
  int m_head = 0, m_tail = 0;
  logic [DW-1:0] slot_data [NE];

  // memory model with programmable latency
  int unsigned  cnt = 0;
  logic [AW-1:0] raddr = '0;
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      cnt   <= lat;
      raddr <= mem_addr_o;
    end else if (cnt != 0) cnt <= cnt - 1;
  end
  assign mem_rvalid_i = (cnt == 1);
  assign mem_rdata_i  = slot_data[3'((raddr - BASE - AW'(2*LB)) >> 2)];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // fetch monitor: address and count (R4, R6)
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && mem_req_o) begin
      fetch_cnt++;
      chk(mem_addr_o == BASE + AW'(2*LB) + AW'(m_tail), "R4 fetch addr",
          mem_addr_o, BASE + AW'(2*LB) + AW'(m_tail));
      chk(m_head != m_tail, "R6 fetch while empty", 32'(m_head), 32'(m_tail));
    end
  end

  // all tasks start and end right at a negedge
  task automatic post(input logic [31:0] v);
    slot_data[m_head/4] = v;
    head_inc_i = 1;
    @(negedge clk_i);
    head_inc_i = 0;
    m_head = (m_head + 4) % LB;
  endtask

  task automatic host_read(output logic [31:0] d, output int stall);
    stall = 0;
    rd_req_i = 1;
    #1;
    while (!rd_ack_o && stall < 50) begin
      @(negedge clk_i); #1;
      stall++;
    end
    d = rd_data_o;
    @(negedge clk_i);
    rd_req_i = 0;
    if (d != 32'hFFFF_FFFF || m_head != m_tail) m_tail = (m_tail + 4) % LB;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int st, f0;
    for (int i = 0; i < NE; i++) slot_data[i] = '0;
    idle(3);
    rst_ni = 1;
    @(negedge clk_i); #1;
    // R1 reset state
    chk(head_ptr_o == 0 && tail_ptr_o == 0, "R1 pointers", {head_ptr_o, tail_ptr_o}, 0);
    chk(!irq_status_o && !irq_o, "R1 irq", {irq_status_o, irq_o}, 0);
    chk(irq_mask_o == 1, "R1 mask", irq_mask_o, 1);
    chk(!mem_req_o, "R1 no fetch", mem_req_o, 0);
    @(negedge clk_i);

    // R2 empty read
    host_read(d, st);
    chk(d == 32'hFFFF_FFFF && st == 0, "R2 sentinel", d, 32'hFFFF_FFFF);
    chk(tail_ptr_o == 0, "R2 tail kept", tail_ptr_o, 0);

    // R3/R5/R6 sweep over latency and burst length
    for (int l = 1; l <= 3; l++) begin
      lat = l;
      for (int n = 0; n < NE; n++) begin
        for (int i = 0; i < n; i++) post(32'hC000_0000 | (l << 16) | (n << 8) | i);
        chk(head_ptr_o == PW'(m_head), "R5 head", head_ptr_o, m_head);
        idle(l + 4);
        f0 = fetch_cnt;
        chk(irq_status_o == (n != 0), "R8 status", irq_status_o, n != 0);
        for (int i = 0; i < n; i++) begin
          host_read(d, st);
          chk(d == (32'hC000_0000 | (l << 16) | (n << 8) | i), "R3 order", d,
              32'hC000_0000 | (l << 16) | (n << 8) | i);
          chk(tail_ptr_o == PW'(m_tail), "R3 tail", tail_ptr_o, m_tail);
        end
        host_read(d, st);
        chk(d == 32'hFFFF_FFFF, "R2 drained sentinel", d, 32'hFFFF_FFFF);
        chk(tail_ptr_o == PW'(m_tail), "R2 tail after sentinel", tail_ptr_o, m_tail);
        chk(fetch_cnt - f0 == ((n > 0) ? n - 1 : 0), "R6 fetch count", fetch_cnt - f0, (n > 0) ? n - 1 : 0);
        chk(!irq_status_o, "R8 clears", irq_status_o, 0);
      end
    end

    // R7 stall after post to empty list
    for (int l = 1; l <= 3; l++) begin
      lat = l;
      post(32'hBEEF_0000 + l);
      host_read(d, st);
      chk(st == l + 1, "R7 stall cycles", st, l + 1);
      chk(d == 32'hBEEF_0000 + l, "R7 data", d, 32'hBEEF_0000 + l);
    end

    // R2 head strobe coincident with an empty read
    slot_data[m_head/4] = 32'h1234_5678;
    head_inc_i = 1; rd_req_i = 1; #1;
    chk(rd_ack_o && rd_data_o == 32'hFFFF_FFFF, "R2 race sentinel", rd_data_o, 32'hFFFF_FFFF);
    @(negedge clk_i);
    head_inc_i = 0; rd_req_i = 0;
    m_head = (m_head + 4) % LB;
    idle(5);
    host_read(d, st);
    chk(d == 32'h1234_5678, "R3 after race", d, 32'h1234_5678);

    // R8/R9 interrupt and mask
    #1;
    chk(!irq_o && irq_mask_o, "R9 masked empty", irq_o, 0);
    post(32'h0000_00AA);
    #1;
    chk(irq_status_o && !irq_o, "R9 masked pending", {irq_status_o, irq_o}, 2);
    @(negedge clk_i);
    mask_we_i = 1; mask_d_i = 0;
    @(negedge clk_i);
    mask_we_i = 0; #1;
    chk(irq_o && !irq_mask_o, "R9 unmasked", irq_o, 1);
    @(negedge clk_i);
    idle(5);
    host_read(d, st);
    #1;
    chk(!irq_status_o && !irq_o, "R8 auto clear", {irq_status_o, irq_o}, 0);
    @(negedge clk_i);
    mask_we_i = 1; mask_d_i = 1;
    @(negedge clk_i);
    mask_we_i = 0;
    post(32'h0000_00BB);
    #1;
    chk(irq_status_o && !irq_o, "R9 remasked", {irq_status_o, irq_o}, 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule